// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-facing register file of a single bus-master DMA channel. The host reads and writes three registers through a narrow register port: a command register, a status register and the 32-bit base address of the descriptor table. Byte enables are not used. Instead, every access carries a byte offset and an access size of one, two or four bytes.

A change of the command start bit from 0 to 1 does three things. It reloads the current descriptor pointer from the table base, marks the channel active, and sends a one-cycle start pulse to the descriptor engine. Clearing the start bit never aborts a transfer. The channel stays active until the engine reports that the transfer is complete. A device interrupt passes straight through to the host interrupt line, and its rising edge is also recorded as a sticky status flag.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake and it never applies back-pressure. Host writes take effect at the clock edge on which `host_wr` is high. Reads are combinational from `host_sel`, `host_off` and `host_size`.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the command, status and table base registers read zero, `cur_ptr` is zero, the channel is inactive and `eng_start` is low.
- R2: Register select `host_sel` is 0 for command, 1 for status and 2 for table base. A command write stores only bit 0 (start) and bit 3 (direction, also driven on `xfer_dir`). Every other command bit reads back as zero.
- R3: A command write that changes start from 0 to 1 loads `cur_ptr` from the table base at that clock edge. If the channel was inactive, it also sets status bit 0 (active) and raises `eng_start` for exactly one cycle after that edge. If the channel was already active, no pulse is issued.
- R4: A command write whose bit 0 equals the stored start bit causes no start or stop action. `cur_ptr` is not reloaded and no pulse is issued, but the direction bit is still updated.
- R5: A command write that clears the start bit while the channel is active leaves status bit 0 set. It stays set until `eng_done`.
- R6: An `eng_done` pulse clears status bit 0 at that clock edge.
- R7: A table base write replaces only the addressed bytes. Size 0 addresses 1 byte, size 1 addresses 2 bytes, and sizes 2 and 3 address 4 bytes. Lanes start at byte `host_off`, take data from the low bytes of `host_wdata`, and lanes past byte 3 are dropped. Base bits [1:0] always stay zero.
- R8: A table base read returns the register shifted right by 8×`host_off`, masked to the access size.
- R9: `host_irq` follows `dev_irq` combinationally. A rising edge of `dev_irq` sets status bit 2 (interrupt). A low `dev_irq` leaves the status unchanged.
- R10: `eng_err` sets status bit 1 (error). Writing 1 to status bit 1 or bit 2 clears that bit, and a set in the same cycle wins. Status bit 0 cannot be changed by a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 status, 2 table base |
| host_off | input | 2 | Byte offset of the access |
| host_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| host_wdata | input | 32 | Write data, aligned at bit 0 |
| host_rdata | output | 32 | Read data for the selected register |
| dev_irq | input | 1 | Interrupt level from the attached device |
| host_irq | output | 1 | Interrupt level to the host |
| eng_start | output | 1 | One-cycle launch pulse to the descriptor engine |
| eng_done | input | 1 | Pulse from the engine: transfer finished |
| eng_err | input | 1 | Pulse from the engine: transfer error |
| xfer_dir | output | 1 | Stored direction bit |
| table_base | output | 32 | Descriptor table base address |
| cur_ptr | output | 32 | Current descriptor pointer |

## Verification
Corrupted state in this block shows up at the ports by the next cycle at the latest. A lost active flag or an extra start pulse appears as an `eng_start` pulse that should not be there, or as a missing one. A wrong lane mask leaves a neighbouring base byte altered, which the next narrow read exposes. A stale edge register for the start bit or the interrupt shows up as a pointer reload or a status flag that did not happen or happened twice. For this reason the checks read back the neighbouring byte lanes and count start pulses over whole sequences, instead of sampling only the cycle after each write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACTIVE_BIT = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_INTR_BIT   = 2;
endpackage

// File: rtl/dcr_base_reg.sv
module dcr_base_reg #(
  parameter  int REG_W = 32,
  localparam int NB    = REG_W / 8,
  localparam int OW    = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OW-1:0]    off,
  input  logic [1:0]       size,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] rdata
);
  logic [OW:0]      cnt;
  logic [REG_W-1:0] wshift;
  logic [REG_W-1:0] rshift;
  logic [REG_W-1:0] rmask;

  always_comb begin
    case (size)
      2'd0:    cnt = (OW+1)'(1);
      2'd1:    cnt = (OW+1)'(2);
      default: cnt = (OW+1)'(NB);
    endcase
  end

  assign wshift = wdata << {off, 3'b000};
  assign rshift = base_q >> {off, 3'b000};

  always_comb begin
    if (int'(cnt) >= NB) rmask = '1;
    else                 rmask = (REG_W'(1) << {cnt, 3'b000}) - REG_W'(1);
  end

  assign rdata = rshift & rmask;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam logic [7:0] KEEP = (g == 0) ? 8'hFC : 8'hFF;
    logic hit;
    always_comb hit = (g >= int'(off)) && (g < int'(off) + int'(cnt));
    always_ff @(posedge clk) begin
      if (!rst_n)            base_q[8*g +: 8] <= 8'h00;
      else if (wr_en && hit) base_q[8*g +: 8] <= wshift[8*g +: 8] & KEEP;
    end
  end
endmodule

// File: rtl/dcr_cmd_ctl.sv
module dcr_cmd_ctl #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_start,
  input  logic             wr_dir,
  input  logic             eng_done,
  input  logic [REG_W-1:0] base,
  output logic             start_q,
  output logic             dir_q,
  output logic             active_q,
  output logic             start_pulse,
  output logic [REG_W-1:0] ptr_q
);
  logic rise;

  assign rise = wr_en && wr_start && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q     <= 1'b0;
      dir_q       <= 1'b0;
      active_q    <= 1'b0;
      start_pulse <= 1'b0;
      ptr_q       <= '0;
    end else begin
      start_pulse <= 1'b0;
      if (wr_en) begin
        start_q <= wr_start;
        dir_q   <= wr_dir;
      end
      if (eng_done) active_q <= 1'b0;
      if (rise) begin
        ptr_q <= base;
        if (!active_q) begin
          active_q    <= 1'b1;
          start_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dcr_stat.sv
module dcr_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic clr_err,
  input  logic clr_intr,
  input  logic eng_err,
  input  logic dev_irq,
  output logic err_q,
  output logic intr_q
);
  logic irq_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      intr_q <= 1'b0;
      irq_d  <= 1'b0;
    end else begin
      irq_d <= dev_irq;
      if (eng_err)               err_q <= 1'b1;
      else if (wr_en && clr_err) err_q <= 1'b0;
      if (dev_irq && !irq_d)      intr_q <= 1'b1;
      else if (wr_en && clr_intr) intr_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter  int REG_W = 32,
  localparam int NB    = REG_W / 8,
  localparam int OW    = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [OW-1:0]    host_off,
  input  logic [1:0]       host_size,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             dev_irq,
  output logic             host_irq,
  output logic             eng_start,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             xfer_dir,
  output logic [REG_W-1:0] table_base,
  output logic [REG_W-1:0] cur_ptr
);
  reg_sel_e         sel;
  logic             wr_cmd, wr_stat, wr_base;
  logic             start_q, active_q, err_q, intr_q;
  logic [REG_W-1:0] base_rd;
  logic [7:0]       cmd_rd, stat_rd;

  assign sel     = reg_sel_e'(host_sel);
  assign wr_cmd  = host_wr && (sel == SEL_CMD);
  assign wr_stat = host_wr && (sel == SEL_STAT);
  assign wr_base = host_wr && (sel == SEL_BASE);

  dcr_base_reg #(.REG_W(REG_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_base),
    .off    (host_off),
    .size   (host_size),
    .wdata  (host_wdata),
    .base_q (table_base),
    .rdata  (base_rd)
  );

  dcr_cmd_ctl #(.REG_W(REG_W)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_cmd),
    .wr_start    (host_wdata[CMD_START_BIT]),
    .wr_dir      (host_wdata[CMD_DIR_BIT]),
    .eng_done    (eng_done),
    .base        (table_base),
    .start_q     (start_q),
    .dir_q       (xfer_dir),
    .active_q    (active_q),
    .start_pulse (eng_start),
    .ptr_q       (cur_ptr)
  );

  dcr_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_stat),
    .clr_err  (host_wdata[ST_ERR_BIT]),
    .clr_intr (host_wdata[ST_INTR_BIT]),
    .eng_err  (eng_err),
    .dev_irq  (dev_irq),
    .err_q    (err_q),
    .intr_q   (intr_q)
  );

  assign host_irq = dev_irq;

  always_comb begin
    cmd_rd                = 8'h00;
    cmd_rd[CMD_START_BIT] = start_q;
    cmd_rd[CMD_DIR_BIT]   = xfer_dir;
    stat_rd               = 8'h00;
    stat_rd[ST_ACTIVE_BIT] = active_q;
    stat_rd[ST_ERR_BIT]    = err_q;
    stat_rd[ST_INTR_BIT]   = intr_q;
  end

  always_comb begin
    case (sel)
      SEL_CMD:  host_rdata = REG_W'(cmd_rd);
      SEL_STAT: host_rdata = REG_W'(stat_rd);
      SEL_BASE: host_rdata = base_rd;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [1:0]       host_sel,
  input logic [REG_W-1:0] host_wdata,
  input logic             start_q,
  input logic             active_q,
  input logic             err_q,
  input logic             intr_q,
  input logic             eng_start,
  input logic             eng_done,
  input logic             eng_err,
  input logic             dev_irq,
  input logic [REG_W-1:0] table_base
);
  AST_PULSE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> !eng_start); // R3
  AST_PULSE_WITH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> active_q); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R3
  AST_SAME_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd0 && host_wdata[0] == start_q) |=> !eng_start); // R4
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !eng_done) |=> active_q); // R5
  AST_DONE_DEACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (!active_q || eng_start)); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    table_base[1:0] == 2'b00); // R7
  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq) |=> intr_q); // R9
  AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err_q); // R10
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .start_q    (start_q),
  .active_q   (active_q),
  .err_q      (err_q),
  .intr_q     (intr_q),
  .eng_start  (eng_start),
  .eng_done   (eng_done),
  .eng_err    (eng_err),
  .dev_irq    (dev_irq),
  .table_base (table_base)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [1:0]  host_off = 2'd0;
  logic [1:0]  host_size = 2'd2;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        dev_irq = 1'b0;
  logic        host_irq;
  logic        eng_start;
  logic        eng_done = 1'b0;
  logic        eng_err = 1'b0;
  logic        xfer_dir;
  logic [31:0] table_base;
  logic [31:0] cur_ptr;

  always #5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dev_irq(dev_irq), .host_irq(host_irq),
    .eng_start(eng_start), .eng_done(eng_done), .eng_err(eng_err),
    .xfer_dir(xfer_dir), .table_base(table_base), .cur_ptr(cur_ptr)
  );

  typedef struct {
    string       req;
    logic [31:0] got;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done_flag = 1'b0;

  always @(posedge clk) if (rst_n && eng_start) pulses++;

  // monitor: pops scoreboard items and compares them
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (it.got !== it.exp) begin
        bad++;
        $display("FAIL %s got=%h exp=%h", it.req, it.got, it.exp);
      end
    end
  end

  task automatic push(input string req, input logic [31:0] got, input logic [31:0] exp);
    item_t it;
    it.req = req; it.got = got; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] size, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_off = off; host_size = size; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] size, output logic [31:0] d);
    host_sel = sel; host_off = off; host_size = size;
    #1 d = host_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 2'd0, 2'd2, v); push("R1 cmd", v, 32'h0);
    rd(2'd1, 2'd0, 2'd2, v); push("R1 status", v, 32'h0);
    rd(2'd2, 2'd0, 2'd2, v); push("R1 base", v, 32'h0);
    push("R1 ptr", cur_ptr, 32'h0);
    push("R1 start", {31'd0, eng_start}, 32'h0);

    // R2 only start and dir stored
    p0 = pulses;
    wr(2'd0, 2'd0, 2'd0, 32'hFE);
    rd(2'd0, 2'd0, 2'd2, v); push("R2 cmd readback", v, 32'h08);
    push("R2 dir pin", {31'd0, xfer_dir}, 32'h1);
    push("R2 no pulse", pulses - p0, 0);

    // R7 lane writes, low bits forced zero
    wr(2'd2, 2'd0, 2'd2, 32'h12345677);
    rd(2'd2, 2'd0, 2'd2, v); push("R7 full write", v, 32'h12345674);
    wr(2'd2, 2'd1, 2'd0, 32'hFFFFFFAB);
    rd(2'd2, 2'd0, 2'd2, v); push("R7 byte1 write", v, 32'h1234AB74);
    wr(2'd2, 2'd2, 2'd1, 32'h0000BEEF);
    rd(2'd2, 2'd0, 2'd2, v); push("R7 half write", v, 32'hBEEFAB74);
    wr(2'd2, 2'd0, 2'd0, 32'h000000FF);
    rd(2'd2, 2'd0, 2'd2, v); push("R7 byte0 aligned", v, 32'hBEEFABFC);
    wr(2'd2, 2'd3, 2'd1, 32'h00005A99);
    rd(2'd2, 2'd0, 2'd2, v); push("R7 lane overrun", v, 32'h99EFABFC);

    // R8 shifted reads
    rd(2'd2, 2'd1, 2'd0, v); push("R8 byte1", v, 32'hAB);
    rd(2'd2, 2'd1, 2'd1, v); push("R8 half off1", v, 32'hEFAB);
    rd(2'd2, 2'd3, 2'd0, v); push("R8 byte3", v, 32'h99);
    rd(2'd2, 2'd2, 2'd3, v); push("R8 size3 off2", v, 32'h000099EF);

    // R3 start rising from idle
    p0 = pulses;
    @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd0; host_wdata = 32'h01;
    @(negedge clk);
    host_wr = 1'b0;
    push("R3 pulse high", {31'd0, eng_start}, 32'h1);
    push("R3 ptr reload", cur_ptr, 32'h99EFABFC);
    rd(2'd1, 2'd0, 2'd2, v); push("R3 active", v, 32'h01);
    @(negedge clk);
    push("R3 pulse one cycle", {31'd0, eng_start}, 32'h0);
    push("R3 one pulse", pulses - p0, 1);

    // R4 same start bit: no action
    wr(2'd2, 2'd0, 2'd2, 32'h00001000);
    p0 = pulses;
    wr(2'd0, 2'd0, 2'd0, 32'h09);
    push("R4 ptr kept", cur_ptr, 32'h99EFABFC);
    rd(2'd0, 2'd0, 2'd2, v); push("R4 dir updated", v, 32'h09);
    repeat (2) @(negedge clk);
    push("R4 no pulse", pulses - p0, 0);

    // R5 clearing start keeps channel active
    wr(2'd0, 2'd0, 2'd0, 32'h00);
    repeat (3) @(negedge clk);
    rd(2'd1, 2'd0, 2'd2, v); push("R5 still active", v, 32'h01);
    // R3 restart while active: reload, no pulse
    p0 = pulses;
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    push("R3 reload while active", cur_ptr, 32'h00001000);
    repeat (2) @(negedge clk);
    push("R3 no pulse while active", pulses - p0, 0);
    // R10 host cannot clear active
    wr(2'd1, 2'd0, 2'd0, 32'h01);
    rd(2'd1, 2'd0, 2'd2, v); push("R10 active read-only", v, 32'h01);

    // R6 done clears active
    pulse_done();
    rd(2'd1, 2'd0, 2'd2, v); push("R6 inactive", v, 32'h00);
    p0 = pulses;
    wr(2'd0, 2'd0, 2'd0, 32'h00);
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    @(negedge clk);
    push("R6 relaunch pulse", pulses - p0, 1);
    pulse_done();

    // R9 interrupt pass-through and latch
    @(negedge clk); dev_irq = 1'b1;
    #1 push("R9 irq passthrough", {31'd0, host_irq}, 32'h1);
    @(negedge clk);
    rd(2'd1, 2'd0, 2'd2, v); push("R9 intr set", v, 32'h04);
    dev_irq = 1'b0;
    #1 push("R9 irq low passthrough", {31'd0, host_irq}, 32'h0);
    @(negedge clk);
    rd(2'd1, 2'd0, 2'd2, v); push("R9 low keeps intr", v, 32'h04);
    wr(2'd1, 2'd0, 2'd0, 32'h04);
    repeat (2) @(negedge clk);
    rd(2'd1, 2'd0, 2'd2, v); push("R9 intr cleared, low irq quiet", v, 32'h00);

    // R10 error set and W1C
    @(negedge clk); eng_err = 1'b1;
    @(negedge clk); eng_err = 1'b0;
    rd(2'd1, 2'd0, 2'd2, v); push("R10 err set", v, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h04);
    rd(2'd1, 2'd0, 2'd2, v); push("R10 err kept", v, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h02);
    rd(2'd1, 2'd0, 2'd2, v); push("R10 err cleared", v, 32'h00);

    // R1 reset mid-operation
    wr(2'd0, 2'd0, 2'd0, 32'h08);
    wr(2'd0, 2'd0, 2'd0, 32'h09);
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; dev_irq = 1'b0;
    rd(2'd0, 2'd0, 2'd2, v); push("R1 cmd after reset", v, 32'h0);
    rd(2'd1, 2'd0, 2'd2, v); push("R1 status after reset", v, 32'h0);
    rd(2'd2, 2'd0, 2'd2, v); push("R1 base after reset", v, 32'h0);
    push("R1 ptr after reset", cur_ptr, 32'h0);

    repeat (2) @(negedge clk);
    done_flag = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule